// File: doc/BRIEF.md
# FPGA Passive-Parallel Configuration Sequencer

This block is a hardware state machine that walks a target FPGA through a passive-parallel configuration. A single start strobe launches the run. The block first screens the mode-select straps. It then waits for the target's configuration pins to go quiet, takes over the pins in a fixed order, and pulses nCONFIG while it follows nSTATUS through both edges. Once it has checked CONF_DONE, it opens the configuration control and data enables. A separate data path, outside this block, streams the bitstream and reports when it has finished.

After the stream, an optional early-release phase can run. In that phase the block forces the clock-to-data ratio to x1 and asks the data path for sync words until early-user-mode rises. The block then polls CONF_DONE and aborts if nSTATUS drops. It requests a fixed number of extra DCLK cycles, waits for user mode, releases the pins and checks the final status.

Millisecond timeouts count a 1 kHz tick and restart on every state change. The CONF_DONE poll counts clock cycles instead. The run ends with a done flag or a 3-bit error code, and that result holds until the next start.

Top module: `cfg_seq`

## Requirements
- R1: After reset and while idle, nce_o, nconfig_o, ovr_cfg_n_o and ovr_ncfg_n_o are high, and ctrl_en_o, data_en_o, busy_o, done_o are low. err_o is 0. The error encoding is: 0 none, 1 mode, 2 timeout, 3 nstatus fault, 4 conf-done check, 5 final check.
- R2: A start strobe taken while idle, done or failed is rejected with err_o=1 and busy_o low in the next cycle when any bit of msel_i above bit 0 is set. With msel_i equal to 0 or 1 the run starts and busy_o goes high.
- R3: The first step waits for ncfg_st_i and nst_st_i both high. If TIMEOUT_MS ticks arrive in this step, the run fails with err_o=2 on the last of those ticks.
- R4: Pin takeover happens in a fixed order. First both overrides are enabled (ovr_cfg_n_o and ovr_ncfg_n_o low). nce_o falls exactly one cycle later. nconfig_o is pulsed only after that, once both status inputs read high again.
- R5: nconfig_o stays low until nst_st_i reads low, and then stays high until nst_st_i reads high. Each of these waits fails with err_o=2 on its TIMEOUT_MS-th tick.
- R6: After the pulse, condone_i must be low and condone_oe_i high, otherwise the run fails with err_o=4. If the check passes, ctrl_en_o and data_en_o rise and stay high until stream_done_i.
- R7: While polling CONF_DONE, condone_i high moves on to the extra clocks. Otherwise nst_st_i low fails with err_o=3. If POLL_LIMIT polls pass without either, the run fails with err_o=2. CONF_DONE arriving on the last poll still succeeds.
- R8: dclk_pulse_o is high for exactly DCLK_EXTRA cycles. The block then waits for user_mode_i, and fails with err_o=2 on the TIMEOUT_MS-th tick.
- R9: On user mode, both enables fall, both overrides are released and nce_o rises in the same cycle. One cycle later user_mode_i, condone_i and nst_st_i must all be high. If they are, done_o is raised; if not, the run fails with err_o=5.
- R10: With er_en_i set, after stream_done_i the block asserts sync_push_o and drives ratio_o to 0 until early_user_i. From then on ratio_o follows ratio_i again. If ER_MS ticks arrive first, the run fails with err_o=2.
- R11: err_o and done_o hold until the next accepted start, which clears err_o. A start strobe while busy_o is high has no effect.
- R12: The tick counter clears on every state change, so ticks seen in an earlier step do not count toward the timeout of a later step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe |
| msel_i | input | MSEL_W | Mode-select straps read back from the target |
| tick_i | input | 1 | 1 kHz timeout tick, one clock wide |
| ncfg_st_i | input | 1 | nCONFIG pin level as seen at the target |
| nst_st_i | input | 1 | nSTATUS pin level |
| condone_i | input | 1 | CONF_DONE pin level |
| condone_oe_i | input | 1 | CONF_DONE output-enable status |
| early_user_i | input | 1 | Early-user-mode status |
| user_mode_i | input | 1 | User-mode status |
| er_en_i | input | 1 | Run the early-release phase after the stream |
| stream_done_i | input | 1 | Data path finished streaming |
| ratio_i | input | RATIO_W | Clock-to-data ratio chosen for this bitstream |
| nce_o | output | 1 | Chip enable, active low |
| nconfig_o | output | 1 | nCONFIG drive |
| ovr_cfg_n_o | output | 1 | Config pin override enable, active low |
| ovr_ncfg_n_o | output | 1 | nCONFIG override enable, active low |
| ctrl_en_o | output | 1 | Configuration control enable |
| data_en_o | output | 1 | Configuration data enable |
| ratio_o | output | RATIO_W | Ratio applied to the data path (0 means x1) |
| sync_push_o | output | 1 | Request for all-ones sync words |
| dclk_pulse_o | output | 1 | High for each extra DCLK cycle |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Configuration completed |
| err_o | output | 3 | Error code |

## Verification
The bench covers all eight mode-select codes. This shows that only the two values that differ in bit 0 are accepted, and it runs each accepted one into the pre-check timeout. A reactive target model, in which nSTATUS follows nCONFIG, takes one run from start to done. That run shows the takeover order and exactly fifteen extra clocks. Hand-driven pin runs hold nSTATUS at each level to show that the pulse waits on it. Each of the timeouts is then hit on its exact tick or poll, one count short and on the count. Further runs inject faults: CONF_DONE high or its enable low before streaming, nSTATUS dropping mid-poll, CONF_DONE lost at the final check, and early release with and without early-user-mode. Together they separate every error code from the others.

// File: rtl/cfg_seq_pkg.sv
// Shared types for the configuration sequencer.
// Assumes: states are decoded only inside cfg_seq and cfg_seq_drive.
package cfg_seq_pkg;

    typedef enum logic [4:0] {
        ST_IDLE, ST_PRECHK, ST_QUIET, ST_OVR, ST_SELECT, ST_SETTLE,
        ST_RST_LO, ST_RST_HI, ST_CHECK, ST_STREAM, ST_EARLY, ST_POLL,
        ST_DCLK, ST_WAIT_USER, ST_CLOSE, ST_FINAL, ST_DONE, ST_FAIL
    } seq_state_e;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_MODE    = 3'd1,
        ERR_TIMEOUT = 3'd2,
        ERR_NSTATUS = 3'd3,
        ERR_CONDONE = 3'd4,
        ERR_FINAL   = 3'd5
    } seq_err_e;

    typedef struct packed {
        logic nce;
        logic nconfig;
        logic ovr_cfg_n;
        logic ovr_ncfg_n;
        logic cfg_en;
        logic sync;
        logic dclk;
        logic busy;
        logic done;
    } drive_t;

endpackage

// File: rtl/cfg_seq_cnt.sv
// Saturating event counter used for tick timeouts, poll limits and
// extra-clock counts. last_o flags the event that reaches LIMIT.
// Assumes: LIMIT >= 1; clr_i has priority over inc_i.
module cfg_seq_cnt #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] CAP  = W'(LIMIT);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    // Count events, clear on request, stop at the cap.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
        end else if (inc_i && cnt_q != CAP) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last_o = inc_i && (cnt_q == LAST);

endmodule

// File: rtl/cfg_seq_drive.sv
// Decodes the sequencer state into pin drives and enables.
// Assumes: the fail and idle states both drive the safe idle pattern.
module cfg_seq_drive
    import cfg_seq_pkg::*;
(
    input  seq_state_e state_i,
    output drive_t     drv_o
);
    // Pure decode of the pin pattern per step.
    always_comb begin
        drv_o            = '0;
        drv_o.nce        = 1'b1;
        drv_o.nconfig    = 1'b1;
        drv_o.ovr_cfg_n  = 1'b1;
        drv_o.ovr_ncfg_n = 1'b1;
        case (state_i)
            ST_OVR: begin
                drv_o.ovr_cfg_n  = 1'b0;
                drv_o.ovr_ncfg_n = 1'b0;
            end
            ST_SELECT, ST_SETTLE, ST_RST_HI, ST_CHECK: begin
                drv_o.ovr_cfg_n  = 1'b0;
                drv_o.ovr_ncfg_n = 1'b0;
                drv_o.nce        = 1'b0;
            end
            ST_RST_LO: begin
                drv_o.ovr_cfg_n  = 1'b0;
                drv_o.ovr_ncfg_n = 1'b0;
                drv_o.nce        = 1'b0;
                drv_o.nconfig    = 1'b0;
            end
            ST_STREAM, ST_EARLY, ST_POLL, ST_DCLK, ST_WAIT_USER: begin
                drv_o.ovr_cfg_n  = 1'b0;
                drv_o.ovr_ncfg_n = 1'b0;
                drv_o.nce        = 1'b0;
                drv_o.cfg_en     = 1'b1;
                drv_o.sync       = (state_i == ST_EARLY);
                drv_o.dclk       = (state_i == ST_DCLK);
            end
            default: ;
        endcase
        drv_o.busy = !(state_i inside {ST_IDLE, ST_DONE, ST_FAIL});
        drv_o.done = (state_i == ST_DONE);
    end

endmodule

// File: rtl/cfg_seq.sv
// Passive-parallel configuration sequencer: screens mode straps, takes
// over the pins, pulses nCONFIG against nSTATUS, opens the data path,
// runs optional early release, polls CONF_DONE, adds extra DCLKs, waits
// for user mode and releases the pins.
// Assumes: tick_i is a one-cycle 1 kHz strobe; status inputs are synchronous.
module cfg_seq
    import cfg_seq_pkg::*;
#(
    parameter int MSEL_W     = 3,
    parameter int RATIO_W    = 2,
    parameter int TIMEOUT_MS = 1000,
    parameter int ER_MS      = 1,
    parameter int POLL_LIMIT = 32'h100_0000,
    parameter int DCLK_EXTRA = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [MSEL_W-1:0]  msel_i,
    input  logic               tick_i,
    input  logic               ncfg_st_i,
    input  logic               nst_st_i,
    input  logic               condone_i,
    input  logic               condone_oe_i,
    input  logic               early_user_i,
    input  logic               user_mode_i,
    input  logic               er_en_i,
    input  logic               stream_done_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               nce_o,
    output logic               nconfig_o,
    output logic               ovr_cfg_n_o,
    output logic               ovr_ncfg_n_o,
    output logic               ctrl_en_o,
    output logic               data_en_o,
    output logic [RATIO_W-1:0] ratio_o,
    output logic               sync_push_o,
    output logic               dclk_pulse_o,
    output logic               busy_o,
    output logic               done_o,
    output logic [2:0]         err_o
);
    seq_state_e state_q, state_d;
    seq_err_e   err_q, err_d;
    drive_t     drv;
    logic       step_clr, ms_last, er_last, poll_last, dclk_last;
    logic       msel_ok, quiet;

    assign msel_ok  = ((msel_i >> 1) == '0);
    assign quiet    = ncfg_st_i && nst_st_i;
    assign step_clr = (state_d != state_q);

    cfg_seq_cnt #(.LIMIT(TIMEOUT_MS)) u_ms (
        .clk(clk), .rst_n(rst_n), .clr_i(step_clr), .inc_i(tick_i), .last_o(ms_last));
    cfg_seq_cnt #(.LIMIT(ER_MS)) u_er (
        .clk(clk), .rst_n(rst_n), .clr_i(step_clr), .inc_i(tick_i), .last_o(er_last));
    cfg_seq_cnt #(.LIMIT(POLL_LIMIT)) u_poll (
        .clk(clk), .rst_n(rst_n), .clr_i(step_clr), .inc_i(1'b1), .last_o(poll_last));
    cfg_seq_cnt #(.LIMIT(DCLK_EXTRA)) u_dclk (
        .clk(clk), .rst_n(rst_n), .clr_i(step_clr), .inc_i(1'b1), .last_o(dclk_last));

    cfg_seq_drive u_drive (.state_i(state_q), .drv_o(drv));

    // Next step and error code from the current step and pin status.
    always_comb begin
        state_d = state_q;
        err_d   = err_q;
        case (state_q)
            ST_IDLE, ST_DONE, ST_FAIL: begin
                if (start_i) begin
                    err_d   = ERR_NONE;
                    state_d = ST_PRECHK;
                    if (!msel_ok) begin
                        err_d   = ERR_MODE;
                        state_d = ST_FAIL;
                    end
                end
            end
            ST_PRECHK, ST_SETTLE: begin
                if (quiet) begin
                    state_d = (state_q == ST_PRECHK) ? ST_QUIET : ST_RST_LO;
                end else if (ms_last) begin
                    state_d = ST_FAIL; err_d = ERR_TIMEOUT;
                end
            end
            ST_QUIET:  state_d = ST_OVR;
            ST_OVR:    state_d = ST_SELECT;
            ST_SELECT: state_d = ST_SETTLE;
            ST_RST_LO: begin
                if (!nst_st_i) state_d = ST_RST_HI;
                else if (ms_last) begin state_d = ST_FAIL; err_d = ERR_TIMEOUT; end
            end
            ST_RST_HI: begin
                if (nst_st_i) state_d = ST_CHECK;
                else if (ms_last) begin state_d = ST_FAIL; err_d = ERR_TIMEOUT; end
            end
            ST_CHECK: begin
                if (!condone_i && condone_oe_i) state_d = ST_STREAM;
                else begin state_d = ST_FAIL; err_d = ERR_CONDONE; end
            end
            ST_STREAM: begin
                if (stream_done_i) state_d = er_en_i ? ST_EARLY : ST_POLL;
            end
            ST_EARLY: begin
                if (early_user_i) state_d = ST_POLL;
                else if (er_last) begin state_d = ST_FAIL; err_d = ERR_TIMEOUT; end
            end
            ST_POLL: begin
                if (condone_i) state_d = ST_DCLK;
                else if (!nst_st_i) begin state_d = ST_FAIL; err_d = ERR_NSTATUS; end
                else if (poll_last) begin state_d = ST_FAIL; err_d = ERR_TIMEOUT; end
            end
            ST_DCLK: begin
                if (dclk_last) state_d = ST_WAIT_USER;
            end
            ST_WAIT_USER: begin
                if (user_mode_i) state_d = ST_CLOSE;
                else if (ms_last) begin state_d = ST_FAIL; err_d = ERR_TIMEOUT; end
            end
            ST_CLOSE: state_d = ST_FINAL;
            ST_FINAL: begin
                if (user_mode_i && condone_i && nst_st_i) state_d = ST_DONE;
                else begin state_d = ST_FAIL; err_d = ERR_FINAL; end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State and error registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            err_q   <= ERR_NONE;
        end else begin
            state_q <= state_d;
            err_q   <= err_d;
        end
    end

    assign nce_o        = drv.nce;
    assign nconfig_o    = drv.nconfig;
    assign ovr_cfg_n_o  = drv.ovr_cfg_n;
    assign ovr_ncfg_n_o = drv.ovr_ncfg_n;
    assign ctrl_en_o    = drv.cfg_en;
    assign data_en_o    = drv.cfg_en;
    assign sync_push_o  = drv.sync;
    assign dclk_pulse_o = drv.dclk;
    assign busy_o       = drv.busy;
    assign done_o       = drv.done;
    assign ratio_o      = drv.sync ? '0 : ratio_i;
    assign err_o        = err_q;

    assert_mode_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && (msel_i >> 1) != '0) |=> (err_o == ERR_MODE));
    assert_override_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nce_o) |-> $past(!ovr_cfg_n_o && !ovr_ncfg_n_o));
    assert_pulse_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !nconfig_o |-> (!ovr_ncfg_n_o && !nce_o));
    assert_en_selected_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_en_o |-> (!nce_o && !ovr_cfg_n_o));
    assert_dclk_after_cd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dclk_pulse_o) |-> $past(condone_i));
    assert_done_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (nce_o && ovr_cfg_n_o && ovr_ncfg_n_o && !ctrl_en_o && err_o == ERR_NONE));
    assert_sync_x1_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sync_push_o |-> (ratio_o == '0));
    assert_busy_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (err_o == ERR_NONE));

endmodule

// File: tb/tb_cfg_seq.sv
`timescale 1ns/1ps
module tb_cfg_seq;
    localparam int TMO  = 4;
    localparam int ERT  = 2;
    localparam int POLL = 6;
    localparam int DCLK = 15;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0, tick = 1'b0;
    logic [2:0] msel = '0;
    logic ncfg_man = 1'b1, nst_man = 1'b1, model_on = 1'b0, nst_fault = 1'b0;
    logic ncfg_mdl = 1'b1, nst_mdl = 1'b1;
    logic condone = 1'b0, cdoe = 1'b1, early = 1'b0, user = 1'b0, er_en = 1'b0, sdone = 1'b0;
    logic [1:0] ratio = 2'd3;
    logic ncfg_st, nst_st;
    logic nce_o, nconfig_o, ovr_cfg_n_o, ovr_ncfg_n_o, ctrl_en_o, data_en_o;
    logic [1:0] ratio_o;
    logic sync_push_o, dclk_pulse_o, busy_o, done_o;
    logic [2:0] err_o;
    int total = 0, bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    assign ncfg_st = model_on ? ncfg_mdl : ncfg_man;
    assign nst_st  = model_on ? nst_mdl : nst_man;

    // Target model: pin status follows the nCONFIG drive one half cycle later.
    always @(negedge clk) begin
        ncfg_mdl <= nconfig_o;
        nst_mdl  <= nconfig_o & ~nst_fault;
    end

    cfg_seq #(.MSEL_W(3), .RATIO_W(2), .TIMEOUT_MS(TMO), .ER_MS(ERT),
              .POLL_LIMIT(POLL), .DCLK_EXTRA(DCLK)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .msel_i(msel), .tick_i(tick),
        .ncfg_st_i(ncfg_st), .nst_st_i(nst_st), .condone_i(condone),
        .condone_oe_i(cdoe), .early_user_i(early), .user_mode_i(user),
        .er_en_i(er_en), .stream_done_i(sdone), .ratio_i(ratio),
        .nce_o(nce_o), .nconfig_o(nconfig_o), .ovr_cfg_n_o(ovr_cfg_n_o),
        .ovr_ncfg_n_o(ovr_ncfg_n_o), .ctrl_en_o(ctrl_en_o), .data_en_o(data_en_o),
        .ratio_o(ratio_o), .sync_push_o(sync_push_o), .dclk_pulse_o(dclk_pulse_o),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o));

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic kick(input int m);
        start = 1'b1; msel = 3'(m);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic tickp();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic reset_dut();
        model_on = 0; ncfg_man = 1; nst_man = 1; nst_fault = 0; condone = 0;
        cdoe = 1; early = 0; user = 0; er_en = 0; sdone = 0; tick = 0; start = 0;
        rst_n = 1'b0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
    endtask

    task automatic to_stream();
        model_on = 1;
        kick(0);
        for (int i = 0; i < 40 && !ctrl_en_o; i++) @(negedge clk);
        chk(ctrl_en_o && data_en_o, "R6 enables open", int'(ctrl_en_o), 1);
    endtask

    task automatic end_stream();
        sdone = 1'b1;
        @(negedge clk);
        sdone = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int ko, kn, kc, ke, n;
        @(negedge clk);
        reset_dut();

        // R1 idle drive state after reset
        chk(nce_o && nconfig_o && ovr_cfg_n_o && ovr_ncfg_n_o, "R1 pins idle", int'(nce_o), 1);
        chk(!ctrl_en_o && !data_en_o && !busy_o && !done_o, "R1 flags idle", int'(busy_o), 0);
        chk(err_o == 3'd0, "R1 err", int'(err_o), 0);

        // R2/R3 sweep of every mode-select code
        for (int m = 0; m < 8; m++) begin
            reset_dut();
            ncfg_man = 0;
            kick(m);
            if ((m >> 1) != 0) begin
                chk(err_o == 3'd1 && !busy_o && nce_o, "R2 reject", int'(err_o), 1);
            end else begin
                chk(busy_o && err_o == 3'd0, "R2 accept", int'(err_o), 0);
                repeat (TMO - 1) tickp();
                chk(err_o == 3'd0 && busy_o, "R3 before limit", int'(err_o), 0);
                tickp();
                chk(err_o == 3'd2 && !busy_o, "R3 precheck timeout", int'(err_o), 2);
            end
        end

        // R4/R6/R8/R9 full run against the target model
        reset_dut();
        model_on = 1;
        kick(0);
        ko = -1; kn = -1; kc = -1; ke = -1;
        for (int k = 0; k < 40; k++) begin
            if (ko < 0 && !ovr_cfg_n_o && !ovr_ncfg_n_o) ko = k;
            if (kn < 0 && !nce_o) kn = k;
            if (kc < 0 && !nconfig_o) kc = k;
            if (ke < 0 && ctrl_en_o) ke = k;
            @(negedge clk);
        end
        chk(kn == ko + 1, "R4 nce one cycle after overrides", kn, ko + 1);
        chk(kc > kn, "R4 pulse after select", kc, kn + 1);
        chk(ke > kc && nconfig_o, "R6 enables after pulse", ke, kc + 1);
        cyc(3);
        chk(ctrl_en_o && data_en_o, "R6 enables held", int'(ctrl_en_o), 1);
        end_stream();
        cyc(2);
        chk(!dclk_pulse_o && busy_o, "R7 polling waits", int'(dclk_pulse_o), 0);
        condone = 1;
        @(negedge clk);
        n = 0;
        for (int i = 0; i < 40 && dclk_pulse_o; i++) begin n++; @(negedge clk); end
        chk(n == DCLK, "R8 extra clocks", n, DCLK);
        chk(busy_o && ctrl_en_o && !nce_o, "R8 waiting user", int'(busy_o), 1);
        user = 1;
        @(negedge clk);
        chk(!ctrl_en_o && !data_en_o && nce_o && ovr_cfg_n_o && ovr_ncfg_n_o,
            "R9 closedown", int'(nce_o), 1);
        cyc(2);
        chk(done_o && err_o == 3'd0, "R9 done", int'(done_o), 1);
        cyc(3);
        chk(done_o, "R11 done held", int'(done_o), 1);

        // R5/R12 hand-driven nSTATUS handshake
        reset_dut();
        ncfg_man = 0;
        kick(0);
        repeat (TMO - 1) tickp();
        ncfg_man = 1;
        for (int i = 0; i < 20 && nconfig_o; i++) @(negedge clk);
        cyc(3);
        chk(!nconfig_o, "R5 low held while nstatus high", int'(nconfig_o), 0);
        repeat (TMO - 1) tickp();
        chk(err_o == 3'd0 && !nconfig_o, "R12 counter cleared on step", int'(err_o), 0);
        nst_man = 0;
        @(negedge clk);
        chk(nconfig_o, "R5 release after nstatus low", int'(nconfig_o), 1);
        cyc(2);
        chk(!ctrl_en_o && busy_o, "R5 wait nstatus high", int'(ctrl_en_o), 0);
        nst_man = 1;
        cyc(2);
        chk(ctrl_en_o, "R5 proceeds after nstatus high", int'(ctrl_en_o), 1);

        // R5 timeout in the low phase
        reset_dut();
        kick(1);
        for (int i = 0; i < 20 && nconfig_o; i++) @(negedge clk);
        repeat (TMO - 1) tickp();
        chk(err_o == 3'd0, "R5 before limit", int'(err_o), 0);
        tickp();
        chk(err_o == 3'd2 && nconfig_o, "R5 pulse timeout", int'(err_o), 2);

        // R6 conf-done check failures
        reset_dut();
        model_on = 1; condone = 1;
        kick(0);
        for (int i = 0; i < 30 && busy_o; i++) @(negedge clk);
        chk(err_o == 3'd4 && !ctrl_en_o, "R6 condone high", int'(err_o), 4);
        condone = 0; cdoe = 0;
        kick(0);
        for (int i = 0; i < 30 && busy_o; i++) @(negedge clk);
        chk(err_o == 3'd4, "R6 condone oe low", int'(err_o), 4);

        // R7 nstatus fault while polling
        reset_dut();
        to_stream();
        end_stream();
        nst_fault = 1;
        for (int i = 0; i < 6 && busy_o; i++) @(negedge clk);
        chk(err_o == 3'd3, "R7 nstatus fault", int'(err_o), 3);
        cyc(5);
        chk(err_o == 3'd3, "R11 error held", int'(err_o), 3);
        kick(0);
        chk(err_o == 3'd0 && busy_o, "R11 start clears", int'(err_o), 0);

        // R7 poll limit exact count
        reset_dut();
        to_stream();
        end_stream();
        n = 0;
        for (int i = 0; i < 50 && err_o == 3'd0; i++) begin @(negedge clk); n++; end
        chk(n == POLL && err_o == 3'd2, "R7 poll limit", n, POLL);

        // R7 conf-done on the last poll, then R8 user-mode timeout
        reset_dut();
        to_stream();
        end_stream();
        cyc(POLL - 1);
        chk(err_o == 3'd0, "R7 still polling", int'(err_o), 0);
        condone = 1;
        @(negedge clk);
        chk(dclk_pulse_o && err_o == 3'd0, "R7 last poll wins", int'(dclk_pulse_o), 1);
        for (int i = 0; i < 40 && dclk_pulse_o; i++) @(negedge clk);
        repeat (TMO - 1) tickp();
        chk(err_o == 3'd0 && busy_o, "R8 user wait", int'(err_o), 0);
        tickp();
        chk(err_o == 3'd2 && nce_o && !ctrl_en_o, "R8 user timeout", int'(err_o), 2);

        // R9 final check failure
        reset_dut();
        to_stream();
        end_stream();
        condone = 1;
        @(negedge clk);
        for (int i = 0; i < 40 && dclk_pulse_o; i++) @(negedge clk);
        user = 1; condone = 0;
        for (int i = 0; i < 10 && busy_o; i++) @(negedge clk);
        chk(err_o == 3'd5 && !done_o, "R9 final check", int'(err_o), 5);

        // R10 early release with sync words and ratio override
        reset_dut();
        er_en = 1; ratio = 2'd3;
        to_stream();
        chk(ratio_o == 2'd3 && !sync_push_o, "R10 ratio before", int'(ratio_o), 3);
        end_stream();
        chk(sync_push_o && ratio_o == 2'd0, "R10 x1 forced", int'(ratio_o), 0);
        cyc(2);
        chk(sync_push_o && err_o == 3'd0, "R10 sync continues", int'(sync_push_o), 1);
        early = 1;
        @(negedge clk);
        chk(!sync_push_o && ratio_o == 2'd3, "R10 ratio restored", int'(ratio_o), 3);
        condone = 1; user = 1;
        for (int i = 0; i < 60 && !done_o; i++) @(negedge clk);
        chk(done_o, "R10 completes", int'(done_o), 1);

        // R10 early-release timeout
        reset_dut();
        er_en = 1;
        to_stream();
        end_stream();
        repeat (ERT - 1) tickp();
        chk(err_o == 3'd0 && sync_push_o, "R10 before limit", int'(err_o), 0);
        tickp();
        chk(err_o == 3'd2 && !sync_push_o, "R10 timeout", int'(err_o), 2);

        // R11 start ignored while busy
        reset_dut();
        to_stream();
        kick(6);
        chk(busy_o && err_o == 3'd0 && ctrl_en_o, "R11 busy ignores start", int'(err_o), 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule